// File: doc/BRIEF.md
# DAC Start-Up Sample Gate

This block sits on the stereo sample path that feeds a DAC. Each sample arrives as a signed left/right pair qualified by a one-cycle strobe. When the DAC's power control rises while both ADC channels are powered down, the block enters a warm-up phase. During that phase it replaces every sample with two's-complement zero for a fixed number of sample periods. The default is 1059 periods, about 24 ms at a 44.1 kHz rate. If either ADC channel is already powered, the DAC needs no warm-up, and samples pass through as soon as power is applied.

The warm-up also affects the automatic level control that shares the converter. While the phase runs, the block holds the level-control enable low. Its gain-seed output carries the programmed input volume. When the phase ends, the block emits a one-cycle load strobe, so that level control restarts from that programmed gain.

The block is a three-state machine:
- **OFF**: DAC unpowered.
- **WARM**: warm-up running.
- **PASS**: samples forwarded.

It has five transitions:
- **OFF→WARM**: on a DAC power rise with both ADC bits low.
- **OFF→PASS**: on a DAC power rise with either ADC bit high.
- **WARM→PASS**: on the strobe that completes the count.
- **WARM→OFF**: when DAC power drops mid-phase.
- **PASS→OFF**: when DAC power drops.

Top module: `dac_init_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `gain_load`, `smp_out_valid`, `smp_out_l` and `smp_out_r` are all 0.
- R2: A 0→1 change of `dac_pwr` while `adc_pwr_l` and `adc_pwr_r` are both 0 starts the warm-up. `busy` is 1 from the following cycle.
- R3: The warm-up lasts exactly `INIT_SAMPLES` strobes of `smp_valid`. Clock cycles without a strobe do not advance it.
- R4: Every sample emitted during warm-up, or while `dac_pwr` is 0, is 0 on both channels.
- R5: If either ADC power bit is 1 when `dac_pwr` rises, no warm-up runs. `busy` stays 0 and samples pass unchanged from the next strobe.
- R6: While `busy` is 1, `lvl_en` is 0. `gain_seed` always equals `in_vol`.
- R7: On the strobe that completes the warm-up, `gain_load` goes to 1 for exactly one cycle, in the cycle where `busy` returns to 0. From then on `lvl_en` follows `lvl_en_req`.
- R8: If `dac_pwr` falls during warm-up, the count is discarded and `busy` drops. Output stays zero, and the next qualifying power-up runs a full warm-up again.
- R9: Outputs are registered with one cycle of latency. `smp_out_valid` equals `smp_valid` of the previous cycle, and forwarded samples are bit-exact, including the most negative and most positive values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_pwr | input | 1 | DAC power control |
| adc_pwr_l | input | 1 | Left ADC power control |
| adc_pwr_r | input | 1 | Right ADC power control |
| smp_valid | input | 1 | Input sample strobe |
| smp_in_l | input | SAMPLE_W | Left input sample, signed |
| smp_in_r | input | SAMPLE_W | Right input sample, signed |
| lvl_en_req | input | 1 | Requested level-control enable |
| in_vol | input | GAIN_W | Programmed input volume |
| smp_out_valid | output | 1 | Output sample strobe |
| smp_out_l | output | SAMPLE_W | Left output sample |
| smp_out_r | output | SAMPLE_W | Right output sample |
| lvl_en | output | 1 | Level-control enable after gating |
| gain_seed | output | GAIN_W | Gain to load into level control |
| gain_load | output | 1 | One-cycle gain-seed load strobe |
| busy | output | 1 | Warm-up in progress |

## Verification
The bench first runs a plain power-up with both ADCs off. Long strobe-free gaps are inserted, which separates a strobe counter from a clock counter, and the bench probes one strobe before the end and at the end to catch off-by-one lengths. A second pattern drops DAC power partway through warm-up and then powers up again. This shows whether the count truly restarts, and whether samples stay muted while the DAC is off. A third pattern powers up with one ADC already on, which separates the bypass path from the warm-up path. Forwarded samples include the extreme signed codes, to expose any truncation or sign error in the mux.

// File: rtl/dig_pkg.sv
package dig_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WARM = 2'd1,
        ST_PASS = 2'd2
    } gate_state_t;
endpackage

// File: rtl/dig_rise_det.sv
module dig_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;
endmodule

// File: rtl/dig_sample_timer.sv
module dig_sample_timer #(
    parameter int INIT_SAMPLES = 1059
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CNT_W = $clog2(INIT_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(INIT_SAMPLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (step)      cnt <= last ? '0 : cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);

    // R3: the count never runs past the warm-up length
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_VAL);
endmodule

// File: rtl/dig_init_fsm.sv
module dig_init_fsm
    import dig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dac_pwr,
    input  logic pwr_rise,
    input  logic adc_any,
    input  logic smp_valid,
    input  logic cnt_last,
    output logic busy,
    output logic pass,
    output logic cnt_clr,
    output logic cnt_step,
    output logic gain_load
);
    gate_state_t state, state_nx;
    logic        finish;

    assign finish = (state == ST_WARM) && dac_pwr && smp_valid && cnt_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (pwr_rise) state_nx = adc_any ? ST_PASS : ST_WARM;
            ST_WARM: if (!dac_pwr) state_nx = ST_OFF;
                     else if (finish) state_nx = ST_PASS;
            ST_PASS: if (!dac_pwr) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gain_load <= 1'b0;
        else        gain_load <= finish;
    end

    always_comb begin
        busy     = 1'b0;
        pass     = 1'b0;
        cnt_clr  = 1'b1;
        cnt_step = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_WARM: begin
                busy     = 1'b1;
                cnt_clr  = 1'b0;
                cnt_step = smp_valid;
            end
            ST_PASS: pass = 1'b1;
            default: ;
        endcase
    end

    // R5: a power rise with an ADC on never enters warm-up
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && pwr_rise && adc_any) |=> (state == ST_PASS));
    // R7: the load strobe lasts a single cycle
    a_r7_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        gain_load |=> !gain_load);
    // R8: losing DAC power during warm-up leaves the warm state
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM && !dac_pwr) |=> (state == ST_OFF));
endmodule

// File: rtl/dig_data_gate.sv
module dig_data_gate #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pass,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_in_l,
    input  logic [SAMPLE_W-1:0] smp_in_r,
    output logic                smp_out_valid,
    output logic [SAMPLE_W-1:0] smp_out_l,
    output logic [SAMPLE_W-1:0] smp_out_r
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out_valid <= 1'b0;
            smp_out_l     <= '0;
            smp_out_r     <= '0;
        end else begin
            smp_out_valid <= smp_valid;
            smp_out_l     <= pass ? smp_in_l : '0;
            smp_out_r     <= pass ? smp_in_r : '0;
        end
    end

    // R4: anything emitted while not forwarding is zero
    a_r4_zero_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !pass |=> (smp_out_l == '0 && smp_out_r == '0));
    // R9: output strobe trails the input strobe by one cycle
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> smp_out_valid);
endmodule

// File: rtl/dac_init_gate.sv
module dac_init_gate #(
    parameter int SAMPLE_W     = 16,
    parameter int GAIN_W       = 8,
    parameter int INIT_SAMPLES = 1059
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dac_pwr,
    input  logic                adc_pwr_l,
    input  logic                adc_pwr_r,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_in_l,
    input  logic [SAMPLE_W-1:0] smp_in_r,
    input  logic                lvl_en_req,
    input  logic [GAIN_W-1:0]   in_vol,
    output logic                smp_out_valid,
    output logic [SAMPLE_W-1:0] smp_out_l,
    output logic [SAMPLE_W-1:0] smp_out_r,
    output logic                lvl_en,
    output logic [GAIN_W-1:0]   gain_seed,
    output logic                gain_load,
    output logic                busy
);
    logic pwr_rise, cnt_last, cnt_clr, cnt_step, pass;

    dig_rise_det u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dac_pwr),
        .rise (pwr_rise)
    );

    dig_sample_timer #(.INIT_SAMPLES(INIT_SAMPLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .step (cnt_step),
        .last (cnt_last)
    );

    dig_init_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dac_pwr  (dac_pwr),
        .pwr_rise (pwr_rise),
        .adc_any  (adc_pwr_l | adc_pwr_r),
        .smp_valid(smp_valid),
        .cnt_last (cnt_last),
        .busy     (busy),
        .pass     (pass),
        .cnt_clr  (cnt_clr),
        .cnt_step (cnt_step),
        .gain_load(gain_load)
    );

    dig_data_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .pass         (pass),
        .smp_valid    (smp_valid),
        .smp_in_l     (smp_in_l),
        .smp_in_r     (smp_in_r),
        .smp_out_valid(smp_out_valid),
        .smp_out_l    (smp_out_l),
        .smp_out_r    (smp_out_r)
    );

    assign lvl_en    = lvl_en_req & ~busy;
    assign gain_seed = in_vol;

    // R6: level control is held off for the whole warm-up
    a_r6_lvl_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lvl_en);
    // R7: the load strobe coincides with the end of warm-up
    a_r7_load_end: assert property (@(posedge clk) disable iff (!rst_n)
        gain_load |-> (!busy && $fell(busy)));
endmodule

// File: tb/dac_init_gate_tb.sv
module dac_init_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int G = 8;
    localparam int N = 1059;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dac_pwr = 1'b0, adc_pwr_l = 1'b0, adc_pwr_r = 1'b0;
    logic smp_valid = 1'b0;
    logic [W-1:0] smp_in_l = '0, smp_in_r = '0;
    logic lvl_en_req = 1'b0;
    logic [G-1:0] in_vol = '0;
    logic smp_out_valid, lvl_en, gain_load, busy;
    logic [W-1:0] smp_out_l, smp_out_r;
    logic [G-1:0] gain_seed;

    int checks = 0;
    int errors = 0;
    logic [2*W-1:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_init_gate #(.SAMPLE_W(W), .GAIN_W(G), .INIT_SAMPLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .dac_pwr(dac_pwr),
        .adc_pwr_l(adc_pwr_l), .adc_pwr_r(adc_pwr_r),
        .smp_valid(smp_valid), .smp_in_l(smp_in_l), .smp_in_r(smp_in_r),
        .lvl_en_req(lvl_en_req), .in_vol(in_vol),
        .smp_out_valid(smp_out_valid), .smp_out_l(smp_out_l), .smp_out_r(smp_out_r),
        .lvl_en(lvl_en), .gain_seed(gain_seed), .gain_load(gain_load), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: one strobed sample, expected result pushed to the scoreboard
    task automatic send(input logic [W-1:0] l, input logic [W-1:0] r, input bit muted);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_in_l  = l;
        smp_in_r  = r;
        expq.push_back(muted ? '0 : {l, r});
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_many(input int cnt, input bit muted, input int seed);
        for (int i = 0; i < cnt; i++)
            send(W'(seed + i * 37 + 5), W'(~(seed + i * 11)), muted);
    endtask

    // monitor: compare each emitted sample against the queue (R4, R5, R9)
    always @(negedge clk) begin
        if (rst_n && smp_out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected sample", {smp_out_l, smp_out_r}, 0);
            end else begin
                logic [2*W-1:0] e;
                e = expq.pop_front();
                check({smp_out_l, smp_out_r} == e, "R4/R5/R9 sample data",
                      {smp_out_l, smp_out_r}, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int loads;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && gain_load == 0 && smp_out_valid == 0, "R1 reset ctrl",
              {busy, gain_load, smp_out_valid}, 0);
        check({smp_out_l, smp_out_r} == 0, "R1 reset data", {smp_out_l, smp_out_r}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && gain_load == 0 && smp_out_valid == 0, "R1 after release",
              {busy, gain_load, smp_out_valid}, 0);

        // R4: DAC off -> muted
        send_many(3, 1'b1, 100);

        // Pattern A: plain warm-up
        lvl_en_req = 1'b1;
        in_vol     = 8'h91;
        dac_pwr    = 1'b1;
        @(negedge clk);
        check(busy == 1, "R2 busy after rise", busy, 1);
        check(lvl_en == 0, "R6 lvl_en held low", lvl_en, 0);
        check(gain_seed == 8'h91, "R6 gain_seed", gain_seed, 8'h91);
        repeat (40) @(negedge clk);
        check(busy == 1, "R3 idle clocks do not count", busy, 1);
        send_many(N - 1, 1'b1, 7);
        check(busy == 1, "R3 busy one strobe before end", busy, 1);
        send(16'h1234, 16'h4321, 1'b1);
        check(gain_load == 1, "R7 load pulse at end", gain_load, 1);
        check(busy == 0, "R7 busy clears with load", busy, 0);
        check(lvl_en == 1, "R7 lvl_en follows request", lvl_en, 1);
        @(negedge clk);
        check(gain_load == 0, "R7 load is one cycle", gain_load, 0);
        send(16'h8000, 16'h7fff, 1'b0);
        send(16'h7fff, 16'h8000, 1'b0);
        send_many(4, 1'b0, 900);

        // Pattern B: power drop mid warm-up
        dac_pwr = 1'b0;
        @(negedge clk);
        send_many(2, 1'b1, 300);
        dac_pwr = 1'b1;
        @(negedge clk);
        check(busy == 1, "R2 second warm-up", busy, 1);
        send_many(500, 1'b1, 11);
        dac_pwr = 1'b0;
        @(negedge clk);
        check(busy == 0, "R8 busy drops with power", busy, 0);
        send_many(2, 1'b1, 400);
        dac_pwr = 1'b1;
        @(negedge clk);
        send_many(N - 1, 1'b1, 23);
        check(busy == 1, "R8 count restarted from zero", busy, 1);
        send(16'h0001, 16'hffff, 1'b1);
        check(gain_load == 1, "R8 full cycle then load", gain_load, 1);
        send(16'hffff, 16'h0001, 1'b0);

        // Pattern C: ADC already on -> bypass
        dac_pwr = 1'b0;
        @(negedge clk);
        adc_pwr_r = 1'b1;
        dac_pwr   = 1'b1;
        @(negedge clk);
        check(busy == 0, "R5 no warm-up with ADC on", busy, 0);
        check(lvl_en == 1, "R5 lvl_en not gated", lvl_en, 1);
        loads = 0;
        for (int i = 0; i < 20; i++) begin
            send(W'(i * 1000 + 3), W'(i * 77), 1'b0);
            if (gain_load) loads++;
        end
        check(loads == 0, "R5 no load pulse in bypass", loads, 0);

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R9 all samples emitted", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule